// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

A parameterised bank of general-purpose pins behind a 32-bit memory-mapped register port. Every pin can drive a value with its own output enable. Its input is read back through a two-flop synchroniser. Each pin also has an interrupt detector that senses either a level or a single edge direction, with a selectable polarity. There is no both-edges mode: to catch the opposite edge, software flips the polarity.

Two per-pin enables work independently. One decides whether a trigger is recorded in a sticky status bit, which is cleared by writing one. The other decides whether the pin contributes to the combined interrupt output. A per-pin routing code can also take the pin out of that output entirely. The register port is plain and single-cycle: a write takes effect at the next clock edge, and read data is returned combinationally while a read is presented. No streaming data crosses this block, so it has no valid/ready handshake and no back-pressure.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, each pin's routing register reads 7 and all other registers read 0. `pin_oe`, `pin_out` and `irq_summary` are all 0.
- R2: Bit 9 of a pin's configuration register drives `pin_oe`, and bit 1 of its I/O register drives `pin_out`. Both bits read back as written. Every other bit of these registers reads 0.
- R3: Bit 0 of the I/O register returns the pin input after two synchronising flops. A change is still invisible after one clock edge and visible after two.
- R4: Interrupt configuration layout: bit 0 is the interrupt enable, bit 1 the polarity, bit 2 the mode and bit 3 the status-record enable. With mode 0 (level), a pin triggers on every cycle in which its synchronised input equals the polarity bit.
- R5: With mode 1 (edge), a pin triggers only on a synchronised transition towards the polarity value. A transition the other way causes no trigger.
- R6: Status bit 0 is set by a trigger only when the status-record enable is 1. Otherwise it never rises. When it is set, it can be read three clock edges after the pin changes.
- R7: Writing a 1 to status bit 0 clears it. If a trigger arrives in the same cycle as the clear, the bit stays set. In level mode, a clear written while the level is still active therefore has no effect.
- R8: `irq_summary` is high while any pin has interrupt enable 1, routing code 4, and either its status set or a trigger registered in the previous cycle. With status recording off, an edge gives a one-cycle pulse, and an active level holds the output high.
- R9: A routing code other than 4 (for example 7) removes the pin from `irq_summary`, whatever its enables and status.
- R10: Pin n's group sits at byte address 0x1000+0x10*n: configuration at +0x0, I/O at +0x4, interrupt configuration at +0x8 and status at +0xC. Its routing register sits at 0x400+0x4*n. Unmapped addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (16) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is presented |
| pin_in | input | NUM_PINS (4) | Raw pin inputs |
| pin_out | output | NUM_PINS (4) | Driven pin values |
| pin_oe | output | NUM_PINS (4) | Per-pin output enables |
| irq_summary | output | 1 | Combined interrupt output |

## Verification
The clear-by-write-one of the status bit and the setting of that bit by a new trigger can fall in the same cycle. The bench provokes this in two ways. First, it times an edge so that its registered trigger lands on the same clock edge as the clear write. Second, it clears a level-mode pin while the level is still active. In both cases the status must read 1 afterwards. A second clear, issued once the trigger has gone, must then read 0. A sweep over every interrupt configuration, both routing codes and each pin judges `irq_summary` cycle by cycle against values the bench computes from the enable bits.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // interrupt configuration, packed so that bit 0 is the enable
  typedef struct packed {
    logic raw_en;     // bit 3: record triggers in status
    logic edge_mode;  // bit 2: 1 edge, 0 level
    logic pol;        // bit 1: 1 rising / high
    logic en;         // bit 0: contribute to the summary
  } icfg_t;

  typedef enum logic [1:0] {
    REG_CFG  = 2'd0,
    REG_IO   = 2'd1,
    REG_ICFG = 2'd2,
    REG_STAT = 2'd3
  } grp_reg_e;

  localparam logic [2:0] ROUTE_APPS = 3'd4;
  localparam logic [2:0] ROUTE_NONE = 3'd7;
  localparam int         OE_BIT     = 9;
  localparam int         OUT_BIT    = 1;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      dout   <= '0;
    end else begin
      meta_q <= din;
      dout   <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  smp,     // synchronised pin level
  input  icfg_t cfg,
  input  logic  clr,     // write-one-to-clear strobe
  output logic  status,
  output logic  hit      // trigger registered one cycle
);
  logic prev_q;
  logic active;
  logic trig;

  always_comb begin
    active = (smp == cfg.pol);
    trig   = cfg.edge_mode ? (active && (smp != prev_q)) : active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hit    <= 1'b0;
      status <= 1'b0;
    end else begin
      prev_q <= smp;
      hit    <= trig;
      if (cfg.raw_en && trig)
        status <= 1'b1;
      else if (clr)
        status <= 1'b0;
    end
  end

  AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.raw_en && trig) |=> status); // R6
  AST_RAW_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.raw_en |=> !$rose(status)); // R6
  AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(cfg.raw_en && trig)) |=> !status); // R7
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int ADDR_W   = 16,
  parameter int GRP_BASE = 32'h1000,
  parameter int RT_BASE  = 32'h0400
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_en,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq_summary
);
  localparam int GRP_SH = 4;  // 0x10-byte stride
  localparam int RT_SH  = 2;  // 0x4-byte stride

  logic [NUM_PINS-1:0] sync_q;
  logic [NUM_PINS-1:0] grp_hit, rt_hit, clr_vec, stat_vec, hit_vec, req_vec;
  icfg_t               icfg_q  [NUM_PINS];
  logic [2:0]          route_q [NUM_PINS];
  grp_reg_e            sel;
  logic                wr_go;

  assign sel   = grp_reg_e'(bus_addr[3:2]);
  assign wr_go = bus_en && bus_wr;

  gpio_sync2 #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(sync_q)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam logic [ADDR_W-GRP_SH-1:0] GRP_IDX = (ADDR_W-GRP_SH)'((GRP_BASE >> GRP_SH) + i);
    localparam logic [ADDR_W-RT_SH-1:0]  RT_IDX  = (ADDR_W-RT_SH)'((RT_BASE >> RT_SH) + i);

    assign grp_hit[i] = bus_en && (bus_addr[ADDR_W-1:GRP_SH] == GRP_IDX);
    assign rt_hit[i]  = bus_en && (bus_addr[ADDR_W-1:RT_SH] == RT_IDX);
    assign clr_vec[i] = wr_go && grp_hit[i] && (sel == REG_STAT) && bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pin_oe[i]  <= 1'b0;
        pin_out[i] <= 1'b0;
        icfg_q[i]  <= '0;
        route_q[i] <= ROUTE_NONE;
      end else if (wr_go) begin
        if (grp_hit[i]) begin
          case (sel)
            REG_CFG:  pin_oe[i]  <= bus_wdata[OE_BIT];
            REG_IO:   pin_out[i] <= bus_wdata[OUT_BIT];
            REG_ICFG: icfg_q[i]  <= icfg_t'(bus_wdata[3:0]);
            default:  ;
          endcase
        end
        if (rt_hit[i])
          route_q[i] <= bus_wdata[2:0];
      end
    end

    gpio_irq_detect u_det (
      .clk(clk), .rst_n(rst_n), .smp(sync_q[i]), .cfg(icfg_q[i]),
      .clr(clr_vec[i]), .status(stat_vec[i]), .hit(hit_vec[i])
    );

    assign req_vec[i] = icfg_q[i].en && (route_q[i] == ROUTE_APPS) &&
                        (stat_vec[i] || hit_vec[i]);

    AST_OE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && grp_hit[i] && sel == REG_CFG) |=> (pin_oe[i] == $past(bus_wdata[OE_BIT]))); // R2
  end

  assign irq_summary = |req_vec;

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_wr) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (grp_hit[i]) begin
          case (sel)
            REG_CFG:  bus_rdata[OE_BIT]  = pin_oe[i];
            REG_IO: begin
              bus_rdata[OUT_BIT] = pin_out[i];
              bus_rdata[0]       = sync_q[i];
            end
            REG_ICFG: bus_rdata[3:0]     = icfg_q[i];
            REG_STAT: bus_rdata[0]       = stat_vec[i];
            default:  ;
          endcase
        end
        if (rt_hit[i])
          bus_rdata[2:0] = route_q[i];
      end
    end
  end
endmodule

// File: tb/gpio_irq_bank_test.sv
`timescale 1ns/1ps
module gpio_irq_bank_test;
  localparam int N = 4;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] pin_in = '0, pin_out, pin_oe;
  logic        irq_summary;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_irq_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_summary(irq_summary)
  );

  function automatic logic [15:0] ga(int p, int r);
    return 16'(32'h1000 + 16*p + 4*r);
  endfunction
  function automatic logic [15:0] ra(int p);
    return 16'(32'h400 + 4*p);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    bus_en = 1; bus_wr = 0; bus_addr = a;
    #0.5;
    d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #700000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_n = 1;
    idle(2);
    // R1 reset values
    for (int p = 0; p < N; p++) begin
      rd(ra(p), d);      chk("R1 route reset", d, 7);
      for (int r = 0; r < 4; r++) begin
        rd(ga(p, r), d); chk("R1 group reset", d, 0);
      end
    end
    chk("R1 oe/out/summary reset", {pin_oe, pin_out, 3'b0, irq_summary}, 0);

    // R2 output control, unused bits zero
    wr(ga(0, 0), 32'hFFFF_FFFF);
    rd(ga(0, 0), d); chk("R2 cfg readback", d, 32'h200);
    chk("R2 pin_oe", 32'(pin_oe), 1);
    wr(ga(0, 1), 32'hFFFF_FFFF);
    rd(ga(0, 1), d); chk("R2 io readback", d, 32'h2);
    chk("R2 pin_out", 32'(pin_out), 1);
    wr(ga(0, 0), 0); wr(ga(0, 1), 0);
    chk("R2 cleared", {pin_oe, pin_out}, 0);

    // R3 input synchroniser latency
    @(negedge clk); pin_in[2] = 1;
    @(negedge clk); rd(ga(2, 1), d); chk("R3 one edge", d, 0);
    @(negedge clk); rd(ga(2, 1), d); chk("R3 two edges", d, 1);
    pin_in[2] = 0; idle(3);

    // R10 unmapped addresses read zero, writes ignored
    wr(16'h0000, 32'hFFFF_FFFF); wr(16'h1040, 32'hF); wr(16'h0410, 32'h4);
    rd(16'h0000, d); chk("R10 unmapped 0x0", d, 0);
    rd(16'h1040, d); chk("R10 unmapped past groups", d, 0);
    rd(16'h0410, d); chk("R10 unmapped past routing", d, 0);
    for (int p = 0; p < N; p++) begin
      rd(ga(p, 2), d); chk("R10 no stray write", d, 0);
    end

    // Sweep: pin x config x route (R4..R9)
    for (int p = 0; p < N; p++) begin
      for (int c = 0; c < 16; c++) begin
        for (int rr = 0; rr < 2; rr++) begin
          logic en, pol, edg, raw, rt4, exp_s;
          en = c[0]; pol = c[1]; edg = c[2]; raw = c[3]; rt4 = (rr == 0);
          @(negedge clk); pin_in[p] = ~pol;
          wr(ra(p), rt4 ? 4 : 7);
          wr(ga(p, 2), c);
          idle(4);
          wr(ga(p, 3), 1);
          rd(ga(p, 3), d);  chk("R7 clear inactive", d, 0);
          chk("R8 idle summary", 32'(irq_summary), 0);
          @(negedge clk); pin_in[p] = pol;
          idle(3);
          chk("R8 R9 first cycle", 32'(irq_summary), 32'(en & rt4));
          rd(ga(p, 3), d);  chk("R6 status after 3 edges", d, 32'(raw));
          @(negedge clk);
          exp_s = en & rt4 & (raw | ~edg);
          chk(edg ? "R5 R8 edge second cycle" : "R4 R8 level second cycle",
              32'(irq_summary), 32'(exp_s));
          wr(ga(p, 3), 1);
          rd(ga(p, 3), d);
          chk(edg ? "R7 edge clear" : "R7 level clear overridden", d, 32'(raw & ~edg));
          @(negedge clk); pin_in[p] = ~pol;
          idle(4);
          rd(ga(p, 3), d);
          chk("R5 opposite edge ignored", d, 32'(raw & ~edg));
          chk("R4 R5 inactive summary", 32'(irq_summary), 32'(en & rt4 & raw & ~edg));
          wr(ga(p, 3), 1);
          rd(ga(p, 3), d); chk("R7 final clear", d, 0);
        end
      end
      wr(ga(p, 2), 0); wr(ra(p), 7);
      @(negedge clk); pin_in[p] = 0;
      idle(4); wr(ga(p, 3), 1);
    end

    // R7 trigger and clear in the same cycle: set wins
    wr(ra(1), 4); wr(ga(1, 2), 15);
    idle(3); wr(ga(1, 3), 1);
    @(negedge clk); pin_in[1] = 1;
    @(negedge clk); @(negedge clk);
    bus_en = 1; bus_wr = 1; bus_addr = ga(1, 3); bus_wdata = 1;
    @(negedge clk); bus_en = 0; bus_wr = 0;
    rd(ga(1, 3), d); chk("R7 same-cycle set wins", d, 1);
    chk("R8 summary held by status", 32'(irq_summary), 1);
    wr(ga(1, 3), 1);
    rd(ga(1, 3), d); chk("R7 later clear", d, 0);
    chk("R8 summary drops", 32'(irq_summary), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule